// File: doc/BRIEF.md
# Linked-List Descriptor Queue Manager

This block keeps many hardware packet queues whose descriptors are threaded through one shared link memory. A producer enqueues a descriptor by writing its address to the push port together with a queue number. A consumer dequeues by strobing the pop port with a queue number. The oldest descriptor address of that queue comes back on the read-data output one cycle later. The descriptors never move. Only their link-memory entries, which hold the index of the next descriptor, are rewritten.

Descriptors live in one region, given by a base address, a descriptor size (a power of two) and a first link index. A descriptor's link index is the first link index plus its offset from the base divided by the size. Each queue holds a head index, a tail index and an entry count. A non-empty bitmap and a count-peek port show the queue state without dequeuing. A parameter marks some queues as interrupt-capable, and those queues raise a one-cycle interrupt pulse when they go from empty to holding a descriptor.

Top module: `qm_top`

## Requirements
- R1: Descriptors pushed to one queue are popped from that queue in push order, and each queue is independent of all the others.
- R2: A pushed address maps to its slot by dropping the offset bits below the descriptor size. The popped value is the slot's base address, `DESC_BASE + slot*2^SIZE_LOG2`.
- R3: A pop from an empty queue, with no push to that queue in the same cycle, returns 0 and leaves every count and status bit unchanged.
- R4: `peek_count` shows the number of entries in queue `peek_q` without changing any state, and it never exceeds `NUM_DESC`.
- R5: Bit q of `q_status` is 1 exactly when queue q holds at least one entry. It clears in the cycle after the pop that takes the count to zero.
- R6: `irq[q]` is high for exactly one cycle, the first cycle in which queue q is non-empty after being empty, and only when bit q of `IRQ_MASK` is set.
- R7: A push and a pop to the same queue in one cycle are handled as push first, then pop. On an empty queue the pop returns the descriptor just pushed and the queue stays empty. On a one-entry queue the pop returns the old entry and the new one remains.
- R8: A push to one queue and a pop from a different queue in the same cycle both take full effect.
- R9: `pop_rdata` is updated one clock after a `pop_re` strobe and holds its value until the next strobe.
- R10: After reset every queue is empty, and `q_status`, `irq`, `pop_rdata` and `peek_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_we | input | 1 | Push strobe |
| push_q | input | $clog2(NUM_Q) | Queue to push to |
| push_addr | input | ADDR_W | Descriptor address to enqueue |
| pop_re | input | 1 | Pop strobe |
| pop_q | input | $clog2(NUM_Q) | Queue to pop from |
| pop_rdata | output | ADDR_W | Popped descriptor address, or 0 if the queue was empty |
| peek_q | input | $clog2(NUM_Q) | Queue whose count is shown |
| peek_count | output | $clog2(NUM_DESC+1) | Entry count of `peek_q` |
| q_status | output | NUM_Q | Non-empty bitmap |
| irq | output | NUM_Q | Empty-to-non-empty pulse for interrupt-capable queues |

## Verification
A push and a pop can land in the same cycle, either on the same queue or on two different ones. The bench issues both kinds directly: on an empty queue, on a one-entry queue, and across two queues. It also issues them by chance throughout a long pseudo-random stream in which both strobes are often active together. Its per-queue reference model always applies the push before the pop, so every returned address, count and status bit is judged against that ordering.

// File: rtl/qm_pkg.sv
package qm_pkg;
  localparam int ADDR_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/qm_addr_map.sv
module qm_addr_map
  import qm_pkg::*;
#(
  parameter addr_t DESC_BASE  = 32'h8000_0000,
  parameter int    SIZE_LOG2  = 7,
  parameter int    REGION_IDX = 16,
  parameter int    IDX_W      = 6
) (
  input  addr_t            push_addr,
  output logic [IDX_W-1:0] push_idx,
  input  logic [IDX_W-1:0] pop_idx,
  output addr_t            pop_addr
);
  localparam logic [IDX_W-1:0] START = IDX_W'(REGION_IDX);

  // byte address -> link index, dropping the offset inside a descriptor
  assign push_idx = START + IDX_W'((push_addr - DESC_BASE) >> SIZE_LOG2);
  // link index -> descriptor base address
  assign pop_addr = DESC_BASE + (ADDR_W'(pop_idx - START) << SIZE_LOG2);
endmodule

// File: rtl/qm_link_ram.sv
module qm_link_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 6
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/qm_queue_state.sv
module qm_queue_state #(
  parameter int NUM_Q = 8,
  parameter int IDX_W = 6,
  parameter int CNT_W = 6,
  parameter int QW    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push_en,
  input  logic [QW-1:0]               push_q,
  input  logic [IDX_W-1:0]            push_idx,
  input  logic                        pop_en,
  input  logic [QW-1:0]               pop_q,
  input  logic [IDX_W-1:0]            link_rdata,
  output logic                        link_we,
  output logic [IDX_W-1:0]            link_waddr,
  output logic [IDX_W-1:0]            link_wdata,
  output logic [IDX_W-1:0]            link_raddr,
  output logic                        pop_hit,
  output logic [IDX_W-1:0]            pop_idx,
  output logic [NUM_Q-1:0][CNT_W-1:0] cnt,
  output logic [NUM_Q-1:0][CNT_W-1:0] cnt_nxt
);
  logic [NUM_Q-1:0][IDX_W-1:0] head_r, head_n, tail_r, tail_n;
  logic [NUM_Q-1:0][CNT_W-1:0] cnt_r, cnt_n;
  logic                        same_q;
  logic [CNT_W-1:0]            pop_cnt;
  logic                        upd_en;

  always_comb begin
    head_n     = head_r;
    tail_n     = tail_r;
    cnt_n      = cnt_r;
    link_we    = 1'b0;
    link_waddr = tail_r[push_q];
    link_wdata = push_idx;
    link_raddr = head_r[pop_q];
    same_q     = push_en && (push_q == pop_q);
    pop_cnt    = cnt_r[pop_q];
    pop_hit    = pop_en && ((pop_cnt != '0) || same_q);
    pop_idx    = (pop_cnt == '0) ? push_idx : head_r[pop_q];
    // push step
    if (push_en) begin
      if (cnt_r[push_q] == '0) head_n[push_q] = push_idx;
      else                     link_we        = 1'b1;
      tail_n[push_q] = push_idx;
      cnt_n[push_q]  = cnt_r[push_q] + CNT_W'(1);
    end
    // pop step, sees the push of this cycle
    if (pop_hit) begin
      head_n[pop_q] = (same_q && pop_cnt == CNT_W'(1)) ? push_idx : link_rdata;
      cnt_n[pop_q]  = cnt_n[pop_q] - CNT_W'(1);
    end
  end

  assign upd_en = push_en || pop_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_r <= '0;
      tail_r <= '0;
      cnt_r  <= '0;
    end else if (upd_en) begin
      head_r <= head_n;
      tail_r <= tail_n;
      cnt_r  <= cnt_n;
    end
  end

  assign cnt     = cnt_r;
  assign cnt_nxt = cnt_n;
endmodule

// File: rtl/qm_top.sv
module qm_top
  import qm_pkg::*;
#(
  parameter int          NUM_Q      = 8,
  parameter int          NUM_LINK   = 64,
  parameter int          NUM_DESC   = 32,
  parameter int          REGION_IDX = 16,
  parameter addr_t       DESC_BASE  = 32'h8000_0000,
  parameter int          SIZE_LOG2  = 7,
  parameter logic [NUM_Q-1:0] IRQ_MASK = 8'h0F
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push_we,
  input  logic [$clog2(NUM_Q)-1:0]      push_q,
  input  logic [ADDR_W-1:0]             push_addr,
  input  logic                          pop_re,
  input  logic [$clog2(NUM_Q)-1:0]      pop_q,
  output logic [ADDR_W-1:0]             pop_rdata,
  input  logic [$clog2(NUM_Q)-1:0]      peek_q,
  output logic [$clog2(NUM_DESC+1)-1:0] peek_count,
  output logic [NUM_Q-1:0]              q_status,
  output logic [NUM_Q-1:0]              irq
);
  localparam int QW    = $clog2(NUM_Q);
  localparam int IDX_W = $clog2(NUM_LINK);
  localparam int CNT_W = $clog2(NUM_DESC + 1);

  logic [IDX_W-1:0]            push_idx, pop_idx;
  logic [IDX_W-1:0]            lk_waddr, lk_wdata, lk_raddr, lk_rdata;
  logic                        lk_we, pop_hit;
  addr_t                       pop_addr;
  logic [NUM_Q-1:0][CNT_W-1:0] cnt, cnt_nxt;
  logic [NUM_Q-1:0]            stat_d;
  addr_t                       rdata_n;

  qm_addr_map #(
    .DESC_BASE(DESC_BASE), .SIZE_LOG2(SIZE_LOG2),
    .REGION_IDX(REGION_IDX), .IDX_W(IDX_W)
  ) map_i (
    .push_addr(push_addr), .push_idx(push_idx),
    .pop_idx(pop_idx), .pop_addr(pop_addr)
  );

  qm_link_ram #(.DEPTH(NUM_LINK), .W(IDX_W)) lram_i (
    .clk(clk), .we(lk_we), .waddr(lk_waddr), .wdata(lk_wdata),
    .raddr(lk_raddr), .rdata(lk_rdata)
  );

  qm_queue_state #(.NUM_Q(NUM_Q), .IDX_W(IDX_W), .CNT_W(CNT_W), .QW(QW)) qs_i (
    .clk(clk), .rst_n(rst_n),
    .push_en(push_we), .push_q(push_q), .push_idx(push_idx),
    .pop_en(pop_re), .pop_q(pop_q), .link_rdata(lk_rdata),
    .link_we(lk_we), .link_waddr(lk_waddr), .link_wdata(lk_wdata),
    .link_raddr(lk_raddr), .pop_hit(pop_hit), .pop_idx(pop_idx),
    .cnt(cnt), .cnt_nxt(cnt_nxt)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_stat
    assign q_status[q] = (cnt[q] != '0);
    // IRQ_MASK picks which queues may signal
    if (IRQ_MASK[q]) begin : g_irq
      assign irq[q] = q_status[q] & ~stat_d[q];
    end else begin : g_noirq
      assign irq[q] = 1'b0;
    end
  end

  assign peek_count = cnt[peek_q];
  assign rdata_n    = pop_hit ? pop_addr : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pop_rdata <= '0;
      stat_d    <= '0;
    end else begin
      stat_d <= q_status;
      if (pop_re) pop_rdata <= rdata_n;
    end
  end
endmodule

// File: rtl/qm_top_chk.sv
module qm_top_chk #(
  parameter int               NUM_Q    = 8,
  parameter int               NUM_DESC = 32,
  parameter int               ADDR_W   = 32,
  parameter logic [NUM_Q-1:0] IRQ_MASK = 8'h0F
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          push_we,
  input logic [$clog2(NUM_Q)-1:0]      push_q,
  input logic                          pop_re,
  input logic [$clog2(NUM_Q)-1:0]      pop_q,
  input logic [ADDR_W-1:0]             pop_rdata,
  input logic [$clog2(NUM_DESC+1)-1:0] peek_count,
  input logic [NUM_Q-1:0]              q_status,
  input logic [NUM_Q-1:0]              irq
);
  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_re && !q_status[pop_q] && !(push_we && push_q == pop_q)) |=> (pop_rdata == '0)); // R3

  AST_POP_LIVE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_re && q_status[pop_q]) |=> (pop_rdata != '0)); // R1

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    peek_count <= ($clog2(NUM_DESC+1))'(NUM_DESC)); // R4

  AST_PUSH_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_we && !pop_re) |=> q_status[$past(push_q)]); // R5

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~IRQ_MASK) == '0); // R6

  AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> ((irq & ~(q_status & ~$past(q_status))) == '0)); // R6

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_re |=> $stable(pop_rdata)); // R9
endmodule

bind qm_top qm_top_chk #(
  .NUM_Q(NUM_Q), .NUM_DESC(NUM_DESC), .ADDR_W(qm_pkg::ADDR_W), .IRQ_MASK(IRQ_MASK)
) chk_i (
  .clk(clk), .rst_n(rst_n), .push_we(push_we), .push_q(push_q),
  .pop_re(pop_re), .pop_q(pop_q), .pop_rdata(pop_rdata),
  .peek_count(peek_count), .q_status(q_status), .irq(irq)
);

// File: tb/qm_top_tb_top.sv
module qm_top_tb_top;
  localparam int          NQ    = 8;
  localparam int          ND    = 32;
  localparam logic [31:0] BASE  = 32'h8000_0000;
  localparam logic [7:0]  MASK  = 8'h0F;

  logic        clk, rst_n;
  logic        push_we, pop_re;
  logic [2:0]  push_q, pop_q, peek_q;
  logic [31:0] push_addr, pop_rdata;
  logic [5:0]  peek_count;
  logic [7:0]  q_status, irq;

  int total = 0;
  int bad   = 0;

  qm_top dut_i (
    .clk(clk), .rst_n(rst_n), .push_we(push_we), .push_q(push_q),
    .push_addr(push_addr), .pop_re(pop_re), .pop_q(pop_q),
    .pop_rdata(pop_rdata), .peek_q(peek_q), .peek_count(peek_count),
    .q_status(q_status), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // reference model: per-queue ring of expected addresses
  logic [31:0] mq [NQ][ND];
  int          mh [NQ];
  int          mt [NQ];
  int          mc [NQ];
  bit          used [ND];
  logic [7:0]  mbits, exp_irq;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [31:0] last_pop;
  bit          pop_seen, mon_on;
  int          rot;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_bits();
    logic [7:0] b;
    for (int q = 0; q < NQ; q++) b[q] = (mc[q] != 0);
    return b;
  endfunction

  // scoreboard driver: one cycle of stimulus, model updated push-then-pop
  task automatic do_cycle(input bit pe, input int pq, input int slot, input int low,
                          input bit oe, input int oq);
    logic [31:0] a;
    logic [7:0]  prev;
    string       t;
    @(negedge clk);
    peek_q = 3'(rot);
    #1;
    check("R4 peek", 32'(peek_count), 32'(mc[rot]));
    check("R5 status", 32'(q_status), 32'(mbits));
    check("R6 irq", 32'(irq), 32'(exp_irq));
    rot = (rot + 1) % NQ;
    prev = mbits;
    push_we = pe; push_q = 3'(pq); pop_re = oe; pop_q = 3'(oq);
    push_addr = BASE + 32'(slot) * 32'd128 + 32'(low);
    if (pe) begin
      a = BASE + 32'(slot) * 32'd128;
      mq[pq][mt[pq]] = a; mt[pq] = (mt[pq] + 1) % ND; mc[pq]++;
      used[slot] = 1'b1;
    end
    if (oe) begin
      if (pe && pq == oq)      t = "R7 same-queue";
      else if (pe)             t = "R8 cross-queue";
      else if (mc[oq] == 0)    t = "R3 empty-pop";
      else                     t = "R1 order";
      if (mc[oq] == 0) a = '0;
      else begin
        a = mq[oq][mh[oq]]; mh[oq] = (mh[oq] + 1) % ND; mc[oq]--;
        used[(a - BASE) >> 7] = 1'b0;
        if (a[6:0] != 0) t = "R2 align";
      end
      exp_q.push_back(a);
      tag_q.push_back(t);
    end
    mbits   = model_bits();
    exp_irq = MASK & mbits & ~prev;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) do_cycle(0, 0, 0, 0, 0, 0);
  endtask

  // scoreboard monitor
  always @(posedge clk) pop_seen <= pop_re;
  always @(negedge clk) begin
    if (mon_on) begin
      if (pop_seen) begin
        check(tag_q.pop_front(), pop_rdata, exp_q.pop_front());
        last_pop = pop_rdata;
      end else begin
        check("R9 hold", pop_rdata, last_pop);
      end
    end
  end

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] lcg;
    rst_n = 1'b0; push_we = 0; pop_re = 0; push_q = 0; pop_q = 0; peek_q = 0;
    push_addr = 0; rot = 0; mon_on = 0; last_pop = 0; mbits = 0; exp_irq = 0;
    for (int q = 0; q < NQ; q++) begin mh[q] = 0; mt[q] = 0; mc[q] = 0; end
    for (int s = 0; s < ND; s++) used[s] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    for (int q = 0; q < NQ; q++) begin
      peek_q = 3'(q); #0.1;
      check("R10 peek", 32'(peek_count), 0);
    end
    check("R10 status", 32'(q_status), 0);
    check("R10 irq", 32'(irq), 0);
    check("R10 rdata", pop_rdata, 0);
    mon_on = 1;
    // R1/R6: fill q0 (interrupt-capable) and q5 (not)
    do_cycle(1, 0, 3, 0, 0, 0);
    do_cycle(1, 0, 7, 0, 0, 0);
    do_cycle(1, 5, 9, 0, 0, 0);
    do_cycle(1, 0, 1, 0, 0, 0);
    do_cycle(1, 5, 2, 0, 0, 0);
    idle(8);
    // R1/R5: drain q0 in order
    for (int i = 0; i < 3; i++) do_cycle(0, 0, 0, 0, 1, 0);
    // R3: empty pop leaves state alone
    do_cycle(0, 0, 0, 0, 1, 0);
    idle(8);
    // R2: unaligned address
    do_cycle(1, 1, 12, 8'h35, 0, 0);
    do_cycle(0, 0, 0, 0, 1, 1);
    // R7: same queue, empty then one entry
    do_cycle(1, 2, 14, 0, 1, 2);
    do_cycle(1, 2, 15, 0, 0, 0);
    do_cycle(1, 2, 16, 0, 1, 2);
    do_cycle(0, 0, 0, 0, 1, 2);
    // R8: different queues together
    do_cycle(1, 3, 20, 0, 1, 5);
    do_cycle(1, 6, 21, 0, 1, 3);
    idle(4);
    // mixed pseudo-random stream
    lcg = 32'h1234_5678;
    for (int n = 0; n < 3000; n++) begin
      int s;
      bit pe;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      pe = lcg[16];
      s = -1;
      if (pe) begin
        for (int k = 0; k < ND; k++)
          if (s < 0 && !used[(k + int'(lcg[28:24])) % ND]) s = (k + int'(lcg[28:24])) % ND;
        if (s < 0) pe = 0;
      end
      do_cycle(pe, int'(lcg[20:18]), (s < 0) ? 0 : s, int'(lcg[13:8]) & 127,
               lcg[17] | lcg[30], lcg[31] ? int'(lcg[20:18]) : int'(lcg[23:21]));
    end
    for (int q = 0; q < NQ; q++) while (mc[q] != 0) do_cycle(0, 0, 0, 0, 1, q);
    idle(10);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule